// File: doc/BRIEF.md
# Memory Barrier Ordering Tracker

This block sits beside the dispatch stage of an out-of-order core and keeps memory operations and later barriers in order behind outstanding memory or write barriers. Every barrier dispatched becomes the youngest barrier and is linked to the barrier that was youngest before it. Every memory operation dispatched while a barrier is outstanding is recorded against that youngest barrier. It is flagged as held, so the issue logic keeps it waiting even when its operands are ready.

Barriers retire in program order. A barrier needs no execution of its own, so it may commit from the cycle after its dispatch. The only condition is that the store buffer reports no committed stores still waiting to write back. When the oldest barrier commits, the tags of the memory operations recorded against it are returned as a one-cycle release mask in the following cycle. A squash removes every barrier younger than the squash sequence number. The youngest-barrier pointer then walks back along the chain to the newest surviving barrier. Held operations younger than the squash point are dropped from the release masks. Sequence numbers are compared as plain unsigned values, with no wrap.

Top module: `mem_barrier_order`

## Requirements
- R1: After reset there are no outstanding barriers: bar_count is 0, young_valid is 0, may_commit is 0 and rel_valid is 0.
- R2: An accepted barrier dispatch (disp_valid=1, disp_is_bar=1, no stall, no squash) makes that barrier the youngest: in the cycle after, young_valid is 1, young_seq equals its sequence number and bar_count has risen by one.
- R3: A memory operation dispatch (disp_valid=1, disp_is_bar=0, disp_is_mem=1) raises op_held in the same cycle exactly when a barrier remains outstanding after any commit of that cycle.
- R4: may_commit is 1 exactly when bar_count is non-zero and st_pending is 0. This holds from the cycle after a barrier's dispatch. A bar_commit request while may_commit is 0 has no effect on bar_count or on rel_valid.
- R5: A performed commit retires the oldest barrier and lowers bar_count by one. In the next cycle rel_valid pulses for one cycle, and rel_mask has bit t set for each memory-op tag t held on that barrier.
- R6: A commit clears young_valid only when the committed barrier is the youngest. Otherwise young_seq is unchanged.
- R7: A memory operation held behind a younger barrier is released only when that younger barrier commits, not when an older one does.
- R8: On squash at sequence S, every barrier with sequence number greater than S is removed and young_seq reverts to the newest survivor. young_valid becomes 0 if none survives. Held operations with sequence number greater than S are never released.
- R9: With NBAR barriers outstanding, a barrier dispatch raises bar_stall and is not accepted: bar_count and young_seq are unchanged.
- R10: In a cycle with squash_valid=1, dispatch and bar_commit are ignored.
- R11: A memory operation dispatched in the cycle the only outstanding barrier commits is not held, and it is not included in any release mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | A dispatch event is present |
| disp_is_bar | input | 1 | The dispatched instruction is a memory or write barrier |
| disp_is_mem | input | 1 | The dispatched instruction is a memory operation |
| disp_seq | input | SEQ_W | Sequence number of the dispatched instruction |
| disp_tag | input | TAG_W | Memory-op tag of the dispatched operation |
| bar_commit | input | 1 | Commit logic asks to retire the oldest barrier |
| st_pending | input | 1 | Committed stores still await writeback |
| squash_valid | input | 1 | Squash event |
| squash_seq | input | SEQ_W | Instructions younger than this are squashed |
| bar_stall | output | 1 | Barrier dispatch refused because all slots are in use |
| op_held | output | 1 | Dispatched memory operation must wait on a barrier |
| may_commit | output | 1 | Oldest barrier may commit now |
| rel_valid | output | 1 | Release pulse |
| rel_mask | output | NTAG | Tags released by the barrier that committed last cycle |
| young_valid | output | 1 | A youngest barrier exists |
| young_seq | output | SEQ_W | Sequence number of the youngest barrier |
| bar_count | output | CNT_W | Number of outstanding barriers |

## Verification
On every cycle the assertions check the local invariants. A hold is only raised with a barrier outstanding. A commit only fires through the store-drain and non-empty gate, and it is always followed by a release pulse. A stall is only raised when all slots are full, and a squash blocks commit and dispatch. The youngest barrier never remains younger than a squash point. Only the bench's scenarios can show which tags come out in which mask. Those scenarios cover the walk back to a surviving barrier, the dropping of squashed held operations, and the ordering between a commit and a dispatch in the same cycle, since these depend on earlier history.

// File: rtl/mbo_pkg.sv
package mbo_pkg;
  localparam int DEF_SEQ_W = 8;
  localparam int DEF_NBAR  = 4;
  localparam int DEF_NTAG  = 8;

  // true when sequence a is strictly younger than sequence b (no wrap)
  function automatic logic seq_after(input logic [31:0] a, input logic [31:0] b);
    return a > b;
  endfunction
endpackage

// File: rtl/mbo_alloc.sv
module mbo_alloc #(
  parameter int NBAR = 4,
  localparam int IDX_W = (NBAR > 1) ? $clog2(NBAR) : 1,
  localparam int CNT_W = $clog2(NBAR + 1)
) (
  input  logic [NBAR-1:0]  valid_i,
  input  logic [NBAR-1:0]  predv_i,
  output logic [IDX_W-1:0] free_idx_o,
  output logic             full_o,
  output logic [IDX_W-1:0] old_idx_o,
  output logic [CNT_W-1:0] count_o
);
  always_comb begin
    free_idx_o = '0;
    old_idx_o  = '0;
    for (int i = NBAR - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx_o = IDX_W'(i);
      if (valid_i[i] && !predv_i[i]) old_idx_o = IDX_W'(i);
    end
  end

  assign full_o  = &valid_i;
  assign count_o = CNT_W'($countones(valid_i));
endmodule

// File: rtl/mbo_rollback.sv
module mbo_rollback #(
  parameter int NBAR  = 4,
  parameter int SEQ_W = 8,
  localparam int IDX_W = (NBAR > 1) ? $clog2(NBAR) : 1
) (
  input  logic [NBAR-1:0]  valid_i,
  input  logic [NBAR-1:0]  predv_i,
  input  logic [IDX_W-1:0] pred_i [NBAR],
  input  logic [SEQ_W-1:0] seq_i  [NBAR],
  input  logic             yv_i,
  input  logic [IDX_W-1:0] yidx_i,
  input  logic [SEQ_W-1:0] sq_seq_i,
  output logic [NBAR-1:0]  kill_o,
  output logic             nyv_o,
  output logic [IDX_W-1:0] nyidx_o
);
  import mbo_pkg::*;

  logic             cv;
  logic [IDX_W-1:0] cur;

  always_comb begin
    cv  = yv_i;
    cur = yidx_i;
    for (int i = 0; i < NBAR; i++) begin
      if (cv && seq_after(32'(seq_i[cur]), 32'(sq_seq_i))) begin
        if (predv_i[cur]) cur = pred_i[cur];
        else              cv  = 1'b0;
      end
    end
    nyv_o   = cv;
    nyidx_o = cur;
  end

  for (genvar k = 0; k < NBAR; k++) begin : g_kill
    assign kill_o[k] = valid_i[k] && seq_after(32'(seq_i[k]), 32'(sq_seq_i));
  end
endmodule

// File: rtl/mem_barrier_order.sv
module mem_barrier_order #(
  parameter int SEQ_W = mbo_pkg::DEF_SEQ_W,
  parameter int NBAR  = mbo_pkg::DEF_NBAR,
  parameter int NTAG  = mbo_pkg::DEF_NTAG,
  localparam int TAG_W = (NTAG > 1) ? $clog2(NTAG) : 1,
  localparam int IDX_W = (NBAR > 1) ? $clog2(NBAR) : 1,
  localparam int CNT_W = $clog2(NBAR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic             disp_is_bar,
  input  logic             disp_is_mem,
  input  logic [SEQ_W-1:0] disp_seq,
  input  logic [TAG_W-1:0] disp_tag,
  input  logic             bar_commit,
  input  logic             st_pending,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  output logic             bar_stall,
  output logic             op_held,
  output logic             may_commit,
  output logic             rel_valid,
  output logic [NTAG-1:0]  rel_mask,
  output logic             young_valid,
  output logic [SEQ_W-1:0] young_seq,
  output logic [CNT_W-1:0] bar_count
);
  import mbo_pkg::*;

  // barrier slots, each linked to its predecessor
  logic [NBAR-1:0]  s_valid, s_predv;
  logic [IDX_W-1:0] s_pred [NBAR];
  logic [SEQ_W-1:0] s_seq  [NBAR];
  logic [NTAG-1:0]  s_dep  [NBAR];
  logic [SEQ_W-1:0] tag_seq [NTAG];
  logic             yv;
  logic [IDX_W-1:0] yidx;

  // named internal events
  logic             commit_fire, bar_fire, mem_fire, yv_after, full;
  logic [IDX_W-1:0] free_idx, old_idx, rb_yidx;
  logic             rb_yv;
  logic [NBAR-1:0]  kill;
  logic [NTAG-1:0]  tag_young;

  mbo_alloc #(.NBAR(NBAR)) u_alloc (
    .valid_i(s_valid), .predv_i(s_predv), .free_idx_o(free_idx),
    .full_o(full), .old_idx_o(old_idx), .count_o(bar_count)
  );

  mbo_rollback #(.NBAR(NBAR), .SEQ_W(SEQ_W)) u_rollback (
    .valid_i(s_valid), .predv_i(s_predv), .pred_i(s_pred), .seq_i(s_seq),
    .yv_i(yv), .yidx_i(yidx), .sq_seq_i(squash_seq),
    .kill_o(kill), .nyv_o(rb_yv), .nyidx_o(rb_yidx)
  );

  for (genvar t = 0; t < NTAG; t++) begin : g_tag
    assign tag_young[t] = seq_after(32'(tag_seq[t]), 32'(squash_seq));
  end

  assign may_commit  = (bar_count != '0) && !st_pending;
  assign commit_fire = bar_commit && may_commit && !squash_valid;
  assign yv_after    = yv && !(commit_fire && (yidx == old_idx));
  assign bar_stall   = disp_valid && disp_is_bar && full;
  assign bar_fire    = disp_valid && disp_is_bar && !full && !squash_valid;
  assign mem_fire    = disp_valid && !disp_is_bar && disp_is_mem && !squash_valid;
  assign op_held     = mem_fire && yv_after;
  assign young_valid = yv;
  assign young_seq   = s_seq[yidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid   <= '0;
      s_predv   <= '0;
      yv        <= 1'b0;
      yidx      <= '0;
      rel_valid <= 1'b0;
      rel_mask  <= '0;
      for (int k = 0; k < NBAR; k++) begin
        s_pred[k] <= '0;
        s_seq[k]  <= '0;
        s_dep[k]  <= '0;
      end
      for (int t = 0; t < NTAG; t++) tag_seq[t] <= '0;
    end else begin
      rel_valid <= commit_fire;
      rel_mask  <= commit_fire ? s_dep[old_idx] : '0;
      if (squash_valid) begin
        for (int k = 0; k < NBAR; k++) begin
          if (kill[k]) begin
            s_valid[k] <= 1'b0;
            s_dep[k]   <= '0;
          end else begin
            s_dep[k]   <= s_dep[k] & ~tag_young;
          end
        end
        yv   <= rb_yv;
        yidx <= rb_yidx;
      end else begin
        if (commit_fire) begin
          s_valid[old_idx] <= 1'b0;
          s_dep[old_idx]   <= '0;
          for (int k = 0; k < NBAR; k++)
            if (s_valid[k] && s_predv[k] && (s_pred[k] == old_idx)) s_predv[k] <= 1'b0;
          if (yidx == old_idx) yv <= 1'b0;
        end
        if (mem_fire) begin
          tag_seq[disp_tag] <= disp_seq;
          if (yv_after) s_dep[yidx][disp_tag] <= 1'b1;
        end
        if (bar_fire) begin
          s_valid[free_idx] <= 1'b1;
          s_seq[free_idx]   <= disp_seq;
          s_predv[free_idx] <= yv_after;
          s_pred[free_idx]  <= yidx;
          s_dep[free_idx]   <= '0;
          yv                <= 1'b1;
          yidx              <= free_idx;
        end
      end
    end
  end
endmodule

// File: rtl/mbo_checker.sv
module mbo_checker #(
  parameter int SEQ_W = 8,
  parameter int NBAR  = 4,
  localparam int CNT_W = $clog2(NBAR + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_pending,
  input logic             squash_valid,
  input logic [SEQ_W-1:0] squash_seq,
  input logic             commit_fire,
  input logic             bar_fire,
  input logic             bar_stall,
  input logic             op_held,
  input logic             rel_valid,
  input logic             young_valid,
  input logic [SEQ_W-1:0] young_seq,
  input logic [CNT_W-1:0] bar_count
);
  assert_held_needs_barrier_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_held |-> young_valid);

  assert_commit_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> (!st_pending && bar_count != '0));

  assert_release_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> rel_valid);

  assert_release_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> $past(commit_fire));

  assert_barrier_counted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_fire && !commit_fire) |=> (young_valid && bar_count == CNT_W'($past(bar_count) + 1'b1)));

  assert_young_implies_some_R6: assert property (@(posedge clk) disable iff (!rst_n)
    young_valid |-> (bar_count != '0));

  assert_stall_only_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bar_stall |-> (bar_count == CNT_W'(NBAR)));

  assert_squash_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> (!commit_fire && !bar_fire));

  assert_rollback_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> (!young_valid || young_seq <= $past(squash_seq)));
endmodule

bind mem_barrier_order mbo_checker #(.SEQ_W(SEQ_W), .NBAR(NBAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_pending(st_pending), .squash_valid(squash_valid),
  .squash_seq(squash_seq), .commit_fire(commit_fire), .bar_fire(bar_fire),
  .bar_stall(bar_stall), .op_held(op_held), .rel_valid(rel_valid),
  .young_valid(young_valid), .young_seq(young_seq), .bar_count(bar_count)
);

// File: tb/mem_barrier_order_tb.sv
module mem_barrier_order_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       disp_valid, disp_is_bar, disp_is_mem, bar_commit, st_pending, squash_valid;
  logic [7:0] disp_seq, squash_seq;
  logic [2:0] disp_tag;
  logic       bar_stall, op_held, may_commit, rel_valid, young_valid;
  logic [7:0] rel_mask, young_seq;
  logic [2:0] bar_count;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk = ~clk;

  mem_barrier_order u_dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_is_bar(disp_is_bar),
    .disp_is_mem(disp_is_mem), .disp_seq(disp_seq), .disp_tag(disp_tag),
    .bar_commit(bar_commit), .st_pending(st_pending), .squash_valid(squash_valid),
    .squash_seq(squash_seq), .bar_stall(bar_stall), .op_held(op_held),
    .may_commit(may_commit), .rel_valid(rel_valid), .rel_mask(rel_mask),
    .young_valid(young_valid), .young_seq(young_seq), .bar_count(bar_count)
  );

  typedef struct packed {
    logic       dv, bar, mem;
    logic [7:0] seq;
    logic [2:0] tag;
    logic       cm, stp;
    logic       e_held, e_may;
    logic [2:0] e_cnt;
    logic       e_yv;
    logic [7:0] e_ys;
    logic       e_rv;
    logic [7:0] e_rm;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,8'd0, 3'd0,1'b0,1'b0, 1'b0,1'b0,3'd0,1'b0,8'd0, 1'b0,8'h00},
    '{1'b1,1'b1,1'b0,8'd10,3'd0,1'b0,1'b0, 1'b0,1'b0,3'd1,1'b1,8'd10,1'b0,8'h00},
    '{1'b1,1'b0,1'b1,8'd11,3'd2,1'b0,1'b0, 1'b1,1'b1,3'd1,1'b1,8'd10,1'b0,8'h00},
    '{1'b1,1'b0,1'b1,8'd12,3'd5,1'b0,1'b0, 1'b1,1'b1,3'd1,1'b1,8'd10,1'b0,8'h00},
    '{1'b1,1'b1,1'b0,8'd13,3'd0,1'b0,1'b0, 1'b0,1'b1,3'd2,1'b1,8'd13,1'b0,8'h00},
    '{1'b1,1'b0,1'b1,8'd14,3'd1,1'b0,1'b0, 1'b1,1'b1,3'd2,1'b1,8'd13,1'b0,8'h00},
    '{1'b0,1'b0,1'b0,8'd0, 3'd0,1'b1,1'b1, 1'b0,1'b0,3'd2,1'b1,8'd13,1'b0,8'h00},
    '{1'b0,1'b0,1'b0,8'd0, 3'd0,1'b1,1'b0, 1'b0,1'b1,3'd1,1'b1,8'd13,1'b1,8'h24},
    '{1'b0,1'b0,1'b0,8'd0, 3'd0,1'b0,1'b0, 1'b0,1'b1,3'd1,1'b1,8'd13,1'b0,8'h00},
    '{1'b0,1'b0,1'b0,8'd0, 3'd0,1'b1,1'b0, 1'b0,1'b1,3'd0,1'b0,8'd0, 1'b1,8'h02},
    '{1'b1,1'b0,1'b1,8'd15,3'd3,1'b0,1'b0, 1'b0,1'b0,3'd0,1'b0,8'd0, 1'b0,8'h00}
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; disp_is_bar = 0; disp_is_mem = 0; disp_seq = 0; disp_tag = 0;
    bar_commit = 0; st_pending = 0; squash_valid = 0; squash_seq = 0;
  endtask

  task automatic drv(input logic dv, input logic b, input logic m, input int s, input int t,
                     input logic c, input logic sq, input int sqs);
    @(negedge clk);
    idle();
    disp_valid = dv; disp_is_bar = b; disp_is_mem = m; disp_seq = 8'(s); disp_tag = 3'(t);
    bar_commit = c; squash_valid = sq; squash_seq = 8'(sqs);
    #1;
  endtask

  task automatic edge_();
    @(posedge clk); #2;
    idle();
  endtask

  task automatic step(input logic dv, input logic b, input logic m, input int s, input int t,
                      input logic c, input logic sq, input int sqs);
    drv(dv, b, m, s, t, c, sq, sqs);
    edge_();
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    @(posedge clk); @(posedge clk); #2;
    rst_n = 1;
  endtask

  initial begin
    #(CLK_P * 50000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    do_reset();
    // R1 reset state
    chk("R1", "bar_count", bar_count, 0);
    chk("R1", "young_valid", young_valid, 0);
    chk("R1", "may_commit", may_commit, 0);
    chk("R1", "rel_valid", rel_valid, 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      disp_valid = VEC[i].dv; disp_is_bar = VEC[i].bar; disp_is_mem = VEC[i].mem;
      disp_seq = VEC[i].seq; disp_tag = VEC[i].tag;
      bar_commit = VEC[i].cm; st_pending = VEC[i].stp;
      squash_valid = 0; squash_seq = 0;
      #1;
      chk("R3", $sformatf("row %0d op_held", i), op_held, VEC[i].e_held);
      chk("R4", $sformatf("row %0d may_commit", i), may_commit, VEC[i].e_may);
      @(posedge clk); #2;
      chk("R2", $sformatf("row %0d bar_count", i), bar_count, VEC[i].e_cnt);
      chk("R6", $sformatf("row %0d young_valid", i), young_valid, VEC[i].e_yv);
      if (VEC[i].e_yv) chk("R6", $sformatf("row %0d young_seq", i), young_seq, VEC[i].e_ys);
      chk("R5", $sformatf("row %0d rel_valid", i), rel_valid, VEC[i].e_rv);
      chk("R7", $sformatf("row %0d rel_mask", i), rel_mask, VEC[i].e_rm);
    end

    // R8 rollback to surviving barrier, squashed held op dropped
    do_reset();
    step(1,1,0,20,0,0,0,0);
    step(1,0,1,25,0,0,0,0);
    step(1,1,0,30,0,0,0,0);
    step(1,0,1,35,1,0,0,0);
    step(1,1,0,40,0,0,0,0);
    step(1,0,1,45,2,0,0,0);
    step(0,0,0,0,0,0,1,32);
    chk("R8", "count after squash", bar_count, 2);
    chk("R8", "young_valid after squash", young_valid, 1);
    chk("R8", "young_seq after squash", young_seq, 30);
    step(0,0,0,0,0,1,0,0);
    chk("R5", "mask oldest after squash", rel_mask, 8'h01);
    chk("R6", "young kept on older commit", young_seq, 30);
    step(0,0,0,0,0,1,0,0);
    chk("R8", "squashed op not released valid", rel_valid, 1);
    chk("R8", "squashed op not released mask", rel_mask, 8'h00);
    chk("R6", "young cleared on own commit", young_valid, 0);

    // R8 squash of every barrier
    step(1,1,0,50,0,0,0,0);
    step(1,1,0,60,0,0,0,0);
    step(0,0,0,0,0,0,1,40);
    chk("R8", "all squashed young_valid", young_valid, 0);
    chk("R8", "all squashed count", bar_count, 0);

    // R9 full stall
    step(1,1,0,70,0,0,0,0);
    step(1,1,0,71,0,0,0,0);
    step(1,1,0,72,0,0,0,0);
    step(1,1,0,73,0,0,0,0);
    drv(1,1,0,74,0,0,0,0);
    chk("R9", "bar_stall when full", bar_stall, 1);
    edge_();
    chk("R9", "count held at full", bar_count, 4);
    chk("R9", "young unchanged at full", young_seq, 73);

    // R10 squash wins over commit and dispatch
    step(1,1,0,75,0,1,1,72);
    chk("R10", "count after squash+commit", bar_count, 3);
    chk("R10", "young after squash", young_seq, 72);
    chk("R10", "no release", rel_valid, 0);

    // R11 commit of only barrier with same-cycle memory op
    do_reset();
    step(1,1,0,80,0,0,0,0);
    drv(1,0,1,81,6,1,0,0);
    chk("R11", "op not held", op_held, 0);
    edge_();
    chk("R11", "count zero", bar_count, 0);
    chk("R11", "release mask excludes op", rel_mask, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule